// File: doc/BRIEF.md
# Maskable Interrupt Acknowledge Controller

This block sits beside a small 8-bit processor core. It decides when a maskable interrupt is taken and carries out the acknowledge. Each maskable source has a pending flag and an enable flag, and there is one global enable. Single-cycle event strobes set the pending flags. Software changes the flags through a narrow write port. A fixed-priority encoder reports the lowest-numbered source that is both pending and enabled, so a handler can select its branch after the jump.

The block acknowledges only at an instruction boundary that the core reports as normally executed, so a skipped instruction is finished first. An acknowledge lasts a fixed number of cycles. During it the block clears the global enable, pushes the address of the interrupted instruction to the stack and then loads the program counter with a single fixed vector. A return-from-interrupt strobe pops the saved address, loads it into the program counter and sets the global enable again.

A boot-ROM mode input blocks all acknowledges and leaves the global enable as it is. While that mode is active, an event on a source whose flag is already pending is discarded. Stack pushes and pops are valid/ready handshakes. A transfer happens in a cycle where both valid and ready are high. The block holds valid, and for a push also the data, stable until ready arrives, so the stack may apply back-pressure for any number of cycles.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, all pending bits, all enable bits and the global enable are 0, and `ack_busy`, `push_valid`, `pop_valid` and `pc_load` are low.
- R2: A one-cycle pulse on `src_evt[k]` sets pending bit k at the next clock edge. A write with `wr_target`=0 clears each pending bit whose `wr_data` bit is 0 and leaves a bit unchanged where `wr_data` is 1. If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R3: `irq_req` is high exactly when the global enable is 1 and some bit is set in both `pend_bits` and `en_bits`. A write with `wr_target`=1 loads `en_bits` from `wr_data`. Enabling a source that is already pending raises `irq_req` in the cycle after the write.
- R4: `src_any` is high when any source is both pending and enabled. `src_sel` then gives the lowest index of such a source.
- R5: An acknowledge starts only in a cycle where all of these hold: `insn_start`=1, `skip_next`=0, `irq_req`=1, `boot_mode`=0 and `ack_busy`=0. A boundary with `skip_next`=1 defers the acknowledge to the next boundary.
- R6: In the cycle after an acknowledge starts, the global enable is 0, `ack_busy` is 1, and `push_valid` is high with `push_data` equal to the `pc_now` value sampled in the start cycle.
- R7: `pc_load` pulses with `pc_load_addr`=0x00FF in the seventh cycle of the acknowledge, counting the start cycle as the first, provided the push has been accepted by then. Otherwise it pulses in the cycle in which the push is accepted. `ack_busy` is low in the cycle after that.
- R8: A `reti` pulse while idle, with no acknowledge starting in that cycle, raises `pop_valid`. In the cycle of the pop handshake, `pc_load` is high with `pc_load_addr`=`pop_data`. The global enable is 1 in the cycle after. If an interrupt is still requested, the next normal boundary starts a new acknowledge.
- R9: While `boot_mode`=1, no acknowledge starts and the global enable keeps its value. After `boot_mode` falls, a boundary with the global enable set starts an acknowledge.
- R10: While `boot_mode`=1, an event on a source whose pending bit is already 1 is discarded, so a clearing write in the same cycle takes effect.
- R11: A write with `wr_target`=2 loads the global enable from `wr_data[0]`. Inside a service routine this allows a nested acknowledge.
- R12: While `push_valid` is high and `push_ready` is low, `push_valid` and `push_data` stay unchanged in the next cycle. While `pop_valid` is high and `pop_ready` is low, `pop_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NSRC | One-cycle event strobes, one per source |
| wr_target | input | 2 | Write selector: 0 pending, 1 enable, 2 global enable, 3 no write |
| wr_data | input | NSRC | Write data; the global enable uses bit 0 |
| insn_start | input | 1 | Core is at an instruction boundary |
| skip_next | input | 1 | The instruction at this boundary is being skipped |
| boot_mode | input | 1 | Boot-ROM execution, interrupts blocked |
| reti | input | 1 | Return-from-interrupt strobe |
| pc_now | input | AW | Address of the instruction about to execute |
| push_valid | output | 1 | Stack push request |
| push_ready | input | 1 | Stack accepts the push |
| push_data | output | AW | Return address to push |
| pop_valid | output | 1 | Stack pop request |
| pop_ready | input | 1 | Stack delivers the popped word |
| pop_data | input | AW | Popped return address |
| pc_load | output | 1 | Load program counter this cycle |
| pc_load_addr | output | AW | Address to load |
| irq_req | output | 1 | Interrupt requested |
| src_any | output | 1 | Some source is pending and enabled |
| src_sel | output | IW | Index of the highest-priority active source |
| ack_busy | output | 1 | Acknowledge sequence in progress |
| gie | output | 1 | Global interrupt enable |
| pend_bits | output | NSRC | Pending flags |
| en_bits | output | NSRC | Enable flags |

## Verification
On every cycle the assertions check the following. An event sets its pending flag unless boot-mode loss applies. The encoder's choice is active and has no active source below it. An acknowledge start clears the global enable, and a pop handshake sets it. The vector load never comes before the seventh cycle and comes once the push is done. Both handshakes hold steady under back-pressure. Only the bench's scenarios show the following: the exact return address pushed, deferral across a skipped boundary, the immediate re-acknowledge after a return, nesting through a software write, and the resumption after boot mode ends.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACK  = 2'd1,
    SEQ_RET  = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    WR_PEND = 2'd0,
    WR_EN   = 2'd1,
    WR_GIE  = 2'd2,
    WR_NONE = 2'd3
  } wr_tgt_t;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            boot_mode,
  input  logic            pend_wr,
  input  logic            en_wr,
  input  logic [NSRC-1:0] wr_data,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] en
);

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic evt_ok;
    // in boot mode a repeat event on an already pending source is dropped
    assign evt_ok = src_evt[k] & ~(boot_mode & pend[k]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[k] <= 1'b0;
      end else if (evt_ok) begin
        pend[k] <= 1'b1;
      end else if (pend_wr) begin
        pend[k] <= pend[k] & wr_data[k];
      end
    end

    // R2: an accepted event always leaves the flag set
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_evt[k] && !(boot_mode && pend[k])) |=> pend[k]);

    // R10: boot-mode repeat event loses against a clearing write
    p_boot_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_mode && pend[k] && pend_wr && !wr_data[k]) |=> !pend[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en <= '0;
    else if (en_wr) en <= wr_data;
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] active,
  output logic            any,
  output logic [IW-1:0]   sel
);

  always_comb begin
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active[i]) sel = IW'(i);
    end
  end

  assign any = |active;

  logic [NSRC-1:0] below_sel;
  assign below_sel = (NSRC'(1) << sel) - NSRC'(1);

  // R4: chosen source is active and nothing of higher priority is
  p_sel_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> active[sel]);
  p_sel_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((active & below_sel) == '0));

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_ack_pkg::*;
#(
  parameter int          AW         = 15,
  parameter int          ACK_CYCLES = 7,
  parameter logic [AW-1:0] VECTOR   = AW'(16'h00FF),
  localparam int         CW         = $clog2(ACK_CYCLES),
  localparam logic [CW-1:0] LAST    = CW'(ACK_CYCLES - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_any,
  input  logic          insn_start,
  input  logic          skip_next,
  input  logic          boot_mode,
  input  logic          reti,
  input  logic [AW-1:0] pc_now,
  input  logic          gie_wr,
  input  logic          gie_wdata,
  input  logic          push_ready,
  input  logic          pop_ready,
  input  logic [AW-1:0] pop_data,
  output logic          gie,
  output logic          irq_req,
  output logic          ack_busy,
  output logic          push_valid,
  output logic [AW-1:0] push_data,
  output logic          pop_valid,
  output logic          pc_load,
  output logic [AW-1:0] pc_load_addr
);

  seq_state_t    st;
  logic [CW-1:0] cnt;
  logic          push_done;
  logic [AW-1:0] ret_addr;
  logic          ack_start, ret_start, push_fire, pop_fire, ack_done;

  assign irq_req   = src_any & gie;
  assign ack_start = (st == SEQ_IDLE) & insn_start & ~skip_next & irq_req & ~boot_mode;
  assign ret_start = (st == SEQ_IDLE) & reti & ~ack_start;

  assign push_valid = (st == SEQ_ACK) & ~push_done;
  assign push_data  = ret_addr;
  assign push_fire  = push_valid & push_ready;
  assign pop_valid  = (st == SEQ_RET);
  assign pop_fire   = pop_valid & pop_ready;

  assign ack_done     = (st == SEQ_ACK) & (cnt == LAST) & (push_done | push_fire);
  assign pc_load      = ack_done | pop_fire;
  assign pc_load_addr = ack_done ? VECTOR : pop_data;
  assign ack_busy     = (st == SEQ_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SEQ_IDLE;
      cnt       <= '0;
      push_done <= 1'b0;
      ret_addr  <= '0;
    end else begin
      unique case (st)
        SEQ_IDLE: begin
          if (ack_start) begin
            st        <= SEQ_ACK;
            cnt       <= CW'(1);
            push_done <= 1'b0;
            ret_addr  <= pc_now;
          end else if (ret_start) begin
            st <= SEQ_RET;
          end
        end
        SEQ_ACK: begin
          if (push_fire) push_done <= 1'b1;
          if (cnt != LAST) cnt <= cnt + CW'(1);
          if (ack_done) st <= SEQ_IDLE;
        end
        SEQ_RET: begin
          if (pop_fire) st <= SEQ_IDLE;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         gie <= 1'b0;
    else if (ack_start) gie <= 1'b0;
    else if (pop_fire)  gie <= 1'b1;
    else if (gie_wr)    gie <= gie_wdata;
  end

  // cycles since the last acknowledge start, saturating
  logic [CW:0] since_start;
  always_ff @(posedge clk) begin
    if (!rst_n)             since_start <= '1;
    else if (ack_start)     since_start <= (CW+1)'(1);
    else if (~&since_start) since_start <= since_start + (CW+1)'(1);
  end

  p_gie_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |=> (!gie && push_valid));
  p_ack_not_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_busy && pc_load) |-> (since_start >= (CW+1)'(LAST)));
  p_ack_load_due_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_busy && since_start >= (CW+1)'(LAST) && !push_valid) |-> pc_load);
  p_gie_set_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> gie);
  p_boot_keep_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_mode && !gie_wr && !pop_valid) |=> (gie == $past(gie)));
  p_push_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));
  p_pop_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready) |=> pop_valid);

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int NSRC       = 8,
  parameter int AW         = 15,
  parameter int ACK_CYCLES = 7,
  localparam int IW        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic [1:0]      wr_target,
  input  logic [NSRC-1:0] wr_data,
  input  logic            insn_start,
  input  logic            skip_next,
  input  logic            boot_mode,
  input  logic            reti,
  input  logic [AW-1:0]   pc_now,
  output logic            push_valid,
  input  logic            push_ready,
  output logic [AW-1:0]   push_data,
  output logic            pop_valid,
  input  logic            pop_ready,
  input  logic [AW-1:0]   pop_data,
  output logic            pc_load,
  output logic [AW-1:0]   pc_load_addr,
  output logic            irq_req,
  output logic            src_any,
  output logic [IW-1:0]   src_sel,
  output logic            ack_busy,
  output logic            gie,
  output logic [NSRC-1:0] pend_bits,
  output logic [NSRC-1:0] en_bits
);

  wr_tgt_t tgt;
  assign tgt = wr_tgt_t'(wr_target);

  irq_flags #(.NSRC(NSRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_evt  (src_evt),
    .boot_mode(boot_mode),
    .pend_wr  (tgt == WR_PEND),
    .en_wr    (tgt == WR_EN),
    .wr_data  (wr_data),
    .pend     (pend_bits),
    .en       (en_bits)
  );

  irq_prio_enc #(.NSRC(NSRC)) u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .active(pend_bits & en_bits),
    .any   (src_any),
    .sel   (src_sel)
  );

  irq_ack_seq #(.AW(AW), .ACK_CYCLES(ACK_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_any     (src_any),
    .insn_start  (insn_start),
    .skip_next   (skip_next),
    .boot_mode   (boot_mode),
    .reti        (reti),
    .pc_now      (pc_now),
    .gie_wr      (tgt == WR_GIE),
    .gie_wdata   (wr_data[0]),
    .push_ready  (push_ready),
    .pop_ready   (pop_ready),
    .pop_data    (pop_data),
    .gie         (gie),
    .irq_req     (irq_req),
    .ack_busy    (ack_busy),
    .push_valid  (push_valid),
    .push_data   (push_data),
    .pop_valid   (pop_valid),
    .pc_load     (pc_load),
    .pc_load_addr(pc_load_addr)
  );

  // R3: request only with the global enable and an active source
  p_req_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie && ((pend_bits & en_bits) != '0)));

endmodule

// File: tb/irq_ack_ctrl_bench.sv
module irq_ack_ctrl_bench;
  localparam int NSRC = 8;
  localparam int AW   = 15;
  localparam int IW   = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src_evt, wr_data, pend_bits, en_bits;
  logic [1:0]      wr_target;
  logic            insn_start, skip_next, boot_mode, reti;
  logic [AW-1:0]   pc_now, push_data, pop_data, pc_load_addr;
  logic            push_valid, push_ready, pop_valid, pop_ready, pc_load;
  logic            irq_req, src_any, ack_busy, gie;
  logic [IW-1:0]   src_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_ack_ctrl u_irq_ack_ctrl (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_target(wr_target),
    .wr_data(wr_data), .insn_start(insn_start), .skip_next(skip_next),
    .boot_mode(boot_mode), .reti(reti), .pc_now(pc_now),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
    .pc_load(pc_load), .pc_load_addr(pc_load_addr), .irq_req(irq_req),
    .src_any(src_any), .src_sel(src_sel), .ack_busy(ack_busy), .gie(gie),
    .pend_bits(pend_bits), .en_bits(en_bits)
  );

  // {enable[7:0], events[7:0], expect_any, expect_sel[2:0]}
  localparam logic [19:0] VEC [7] = '{
    {8'hFF, 8'h01, 1'b1, 3'd0},
    {8'hFF, 8'h80, 1'b1, 3'd7},
    {8'hF0, 8'h0C, 1'b0, 3'd0},
    {8'h0C, 8'h0F, 1'b1, 3'd2},
    {8'hFE, 8'h03, 1'b1, 3'd1},
    {8'h00, 8'hFF, 1'b0, 3'd0},
    {8'h81, 8'h81, 1'b1, 3'd0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic write(input logic [1:0] t, input logic [NSRC-1:0] d);
    wr_target = t; wr_data = d;
    cyc();
    wr_target = 2'd3; wr_data = '0;
  endtask

  task automatic pulse(input logic [NSRC-1:0] e);
    src_evt = e;
    cyc();
    src_evt = '0;
  endtask

  // start cycle already driven by caller; walks the rest of the sequence
  task automatic finish_ack(input string tag);
    insn_start = 1'b0;
    for (int k = 2; k <= 6; k++) begin
      cyc();
      chk({tag, " pc_load timing"}, pc_load, (k == 6));
      if (k == 6) chk({tag, " vector"}, pc_load_addr, 15'h00FF);
    end
    cyc();
    chk({tag, " busy cleared"}, ack_busy, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_evt = '0; wr_target = 2'd3; wr_data = '0;
    insn_start = 0; skip_next = 0; boot_mode = 0; reti = 0;
    pc_now = '0; push_ready = 0; pop_ready = 0; pop_data = '0;
    repeat (3) cyc();
    // R1 reset state
    chk("R1 pend", pend_bits, 0); chk("R1 en", en_bits, 0); chk("R1 gie", gie, 0);
    chk("R1 busy", ack_busy, 0); chk("R1 push", push_valid, 0);
    chk("R1 pop", pop_valid, 0); chk("R1 pcl", pc_load, 0);
    rst_n = 1'b1;
    cyc();

    // R4 / R3 encoder table
    foreach (VEC[i]) begin
      write(2'd1, VEC[i][19:12]);
      pulse(VEC[i][11:4]);
      chk("R4 any", src_any, VEC[i][3]);
      if (VEC[i][3]) chk("R4 sel", src_sel, VEC[i][2:0]);
      chk("R3 no req without gie", irq_req, 0);
      write(2'd0, 8'h00);
      chk("R2 cleared by write", pend_bits, 0);
    end

    // R2 set wins over same-cycle clear; write of 1 keeps
    src_evt = 8'h02; wr_target = 2'd0; wr_data = 8'h00;
    cyc(); src_evt = '0; wr_target = 2'd3;
    chk("R2 set wins", pend_bits[1], 1'b1);
    write(2'd0, 8'hFF);
    chk("R2 write 1 keeps", pend_bits[1], 1'b1);
    write(2'd0, 8'h00);

    // R3 enable after pending raises request
    write(2'd1, 8'h00);
    pulse(8'h08);
    write(2'd2, 8'h01);
    chk("R3 gie set no enable", irq_req, 0);
    write(2'd1, 8'h08);
    chk("R3 enable with pending", irq_req, 1);

    // R5 skipped boundary defers
    push_ready = 1'b1;
    insn_start = 1; skip_next = 1; pc_now = 15'h1234;
    cyc(); insn_start = 0; skip_next = 0;
    chk("R5 skip defers", ack_busy, 0);

    // R6 start
    insn_start = 1; pc_now = 15'h1234;
    cyc(); insn_start = 0; pc_now = '0;
    chk("R6 busy", ack_busy, 1); chk("R6 gie cleared", gie, 0);
    chk("R6 push valid", push_valid, 1); chk("R6 push data", push_data, 15'h1234);
    chk("R7 no early load", pc_load, 0);
    finish_ack("R7");
    chk("R6 no req in isr", irq_req, 0);

    // R8 return with pop back-pressure
    reti = 1; cyc(); reti = 0;
    chk("R8 pop valid", pop_valid, 1);
    cyc();
    chk("R12 pop held", pop_valid, 1);
    chk("R8 no load before pop", pc_load, 0);
    pop_ready = 1; pop_data = 15'h1234; #1;
    chk("R8 load on pop", pc_load, 1); chk("R8 pop addr", pc_load_addr, 15'h1234);
    cyc(); pop_ready = 0;
    chk("R8 gie restored", gie, 1); chk("R8 req again", irq_req, 1);

    // R8 immediate re-ack, with R7 push stall
    push_ready = 0;
    insn_start = 1; pc_now = 15'h0456;
    cyc(); insn_start = 0;
    chk("R8 re-ack", ack_busy, 1);
    for (int k = 2; k <= 6; k++) begin
      cyc();
      chk("R7 stall no load", pc_load, 0);
    end
    chk("R12 push held", push_valid, 1); chk("R12 push data", push_data, 15'h0456);
    cyc();
    chk("R7 still waiting", pc_load, 0);
    push_ready = 1; #1;
    chk("R7 load on push", pc_load, 1);
    cyc();
    chk("R7 busy clear after stall", ack_busy, 0);

    // R11 nested via software gie write
    write(2'd1, 8'h09);
    pulse(8'h01);
    chk("R11 masked in isr", irq_req, 0);
    write(2'd2, 8'h01);
    chk("R11 req after gie write", irq_req, 1);
    insn_start = 1; cyc();
    chk("R11 nested ack", ack_busy, 1);
    finish_ack("R11");

    // R9 boot mode blocks, gie kept
    write(2'd2, 8'h01);
    boot_mode = 1; insn_start = 1;
    cyc(); insn_start = 0;
    chk("R9 blocked", ack_busy, 0); chk("R9 gie kept", gie, 1);

    // R10 repeat event lost in boot mode
    src_evt = 8'h01; wr_target = 2'd0; wr_data = 8'hFE;
    cyc(); src_evt = '0; wr_target = 2'd3;
    chk("R10 event lost", pend_bits[0], 1'b0);

    boot_mode = 0; insn_start = 1;
    cyc();
    chk("R9 resumes", ack_busy, 1);
    finish_ack("R9");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule